// File: doc/BRIEF.md
# EEPROM Command Register Unit

This unit gives a host indirect, word-wide access to a small on-chip EEPROM image through two adjacent registers: a command register and a data register. The host writes a command word that carries a start flag, a three-bit opcode and a word address. The unit then reads a word into the data register, stores the data register into a word, or runs a configuration load. Each operation takes a parameterised number of cycles. Two status bits report progress. The busy bit covers the host command. The running bit covers the internal load engine, which also runs by itself after reset.

A write is a two-step sequence. The host first places the word in the data register, then issues the write command. A read result is valid in the data register once busy drops. A strap input reports whether stores are allowed. It appears as a read-only bit in the command register. The host polls the command register until busy and running are both clear before it issues the next command.

Top module: `eeprom_cmd_unit`

## Requirements
- R1: After reset, running (command bit 11) is 1 and busy (bit 15) is 0 for exactly LOAD_CYCLES clock cycles. Running then drops to 0. No store to the word array happens while running is set.
- R2: A command register write made while busy or running is set is ignored. The latched opcode and address do not change, and the operation in progress finishes with its own timing.
- R3: Opcode 3 (write word), issued with bit 15 set while writeEnable is 1, holds busy for ACCESS_LAT cycles. It then stores the data register into the word at command bits 7:0.
- R4: A write-word command completing while writeEnable is 0 leaves the word array unchanged. Busy timing is the same as in R3.
- R5: Opcode 4 (read word) holds busy for ACCESS_LAT cycles. When busy is 0 again, the data register holds the addressed word.
- R6: Opcode 6 (load) sets busy and running together for LOAD_CYCLES cycles. Neither the word array nor the data register changes.
- R7: Any other opcode completes as a no-operation. Busy is high for exactly one cycle, and neither the word array nor the data register changes.
- R8: Reading the command register (offset CMD_OFF, default 0x14) returns these fields: bit 15 is busy, bits 14:12 are the last accepted opcode, bit 11 is running, and bit 10 is the live writeEnable. Bits 9:8 read 0, and bits 7:0 hold the last accepted address. Reset clears the opcode and address fields to 0.
- R9: A command register write with bit 15 clear starts nothing and leaves the latched opcode and address unchanged.
- R10: Host writes to the data register (offset CMD_OFF+1) are ignored while busy or running is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe, one cycle per write |
| regAddr | input | REG_AW | Register offset for writes and reads |
| regWdata | input | 16 | Register write data |
| regRdata | output | 16 | Combinational read data of the register at regAddr (0 for other offsets) |
| writeEnable | input | 1 | Strap reporting that stores to the word array are permitted |

## Verification
A controller stuck outside its idle state shows busy or running set in the command register for longer than the operation's cycle count. A premature return to idle shows the flags dropping early. The bench counts these flags cycle by cycle against ACCESS_LAT, LOAD_CYCLES and the single no-operation cycle, so both faults appear within one operation. Wrong strobes between control and datapath show up either at once in the data register or at the next read of the affected word. A store made while writeEnable is 0 or during a load, and a clobbered data register, are each caught by the following read-back.

// File: rtl/eeprom_cmd_pkg.sv
package eeprom_cmd_pkg;

  localparam logic [2:0] OP_WRITE = 3'd3;
  localparam logic [2:0] OP_READ  = 3'd4;
  localparam logic [2:0] OP_LOAD  = 3'd6;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ACCESS,
    ST_LOAD
  } ctrlState_e;

  // strobes from the controller to the datapath
  typedef struct packed {
    logic memWe;       // store data register into the word array
    logic dataLoad;    // load data register from the word array
    logic hostDataWe;  // accept a host write into the data register
  } dpStrobe_t;

endpackage

// File: rtl/eeprom_cmd_ctrl.sv
module eeprom_cmd_ctrl
  import eeprom_cmd_pkg::*;
#(
  parameter int              REG_AW      = 5,
  parameter logic [REG_AW-1:0] CMD_OFF   = 5'h14,
  parameter int              WORD_AW     = 8,
  parameter int              ACCESS_LAT  = 4,
  parameter int              LOAD_CYCLES = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWe,
  input  logic [REG_AW-1:0]  regAddr,
  input  logic [15:0]        regWdata,
  input  logic               writeEnable,
  output logic               busy,
  output logic               running,
  output logic [2:0]         lastOp,
  output logic [WORD_AW-1:0] lastAddr,
  output dpStrobe_t          stb
);

  localparam logic [REG_AW-1:0] DATA_OFF = CMD_OFF + 1'b1;
  localparam int MAX_DUR = (LOAD_CYCLES > ACCESS_LAT) ? LOAD_CYCLES : ACCESS_LAT;
  localparam int CNT_W   = $clog2(MAX_DUR + 1);

  ctrlState_e       state;
  logic [CNT_W-1:0] cnt;
  logic             idle;
  logic             start;
  logic             done;
  logic [2:0]       newOp;
  logic [3:0]       unusedCmdBits;

  assign unusedCmdBits = regWdata[11:8];
  assign newOp   = regWdata[14:12];
  assign idle    = (state == ST_IDLE);
  assign running = (state == ST_LOAD);
  assign start   = regWe && (regAddr == CMD_OFF) && regWdata[15] && idle;
  assign done    = !idle && (cnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_LOAD;
      cnt      <= CNT_W'(LOAD_CYCLES - 1);
      busy     <= 1'b0;
      lastOp   <= '0;
      lastAddr <= '0;
    end else if (start) begin
      busy     <= 1'b1;
      lastOp   <= newOp;
      lastAddr <= regWdata[WORD_AW-1:0];
      case (newOp)
        OP_LOAD: begin
          state <= ST_LOAD;
          cnt   <= CNT_W'(LOAD_CYCLES - 1);
        end
        OP_READ, OP_WRITE: begin
          state <= ST_ACCESS;
          cnt   <= CNT_W'(ACCESS_LAT - 1);
        end
        default: begin
          state <= ST_ACCESS;
          cnt   <= '0;
        end
      endcase
    end else if (done) begin
      state <= ST_IDLE;
      busy  <= 1'b0;
    end else if (!idle) begin
      cnt <= cnt - 1'b1;
    end
  end

  always_comb begin
    stb            = '0;
    stb.memWe      = done && (state == ST_ACCESS) && (lastOp == OP_WRITE) && writeEnable;
    stb.dataLoad   = done && (state == ST_ACCESS) && (lastOp == OP_READ);
    stb.hostDataWe = regWe && (regAddr == DATA_OFF) && idle;
  end

endmodule

// File: rtl/eeprom_cmd_dpath.sv
module eeprom_cmd_dpath
  import eeprom_cmd_pkg::*;
#(
  parameter int                REG_AW  = 5,
  parameter logic [REG_AW-1:0] CMD_OFF = 5'h14,
  parameter int                WORD_AW = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpStrobe_t          stb,
  input  logic [WORD_AW-1:0] wordAddr,
  input  logic [REG_AW-1:0]  regAddr,
  input  logic [15:0]        regWdata,
  input  logic               busy,
  input  logic               running,
  input  logic [2:0]         lastOp,
  input  logic               writeEnable,
  output logic [15:0]        dataReg,
  output logic [15:0]        regRdata
);

  localparam logic [REG_AW-1:0] DATA_OFF = CMD_OFF + 1'b1;
  localparam int WORDS = 1 << WORD_AW;

  logic [15:0] mem [WORDS];
  logic [7:0]  addrField;

  assign addrField = 8'(wordAddr);

  always_ff @(posedge clk) begin
    if (stb.memWe) mem[wordAddr] <= dataReg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               dataReg <= '0;
    else if (stb.dataLoad)   dataReg <= mem[wordAddr];
    else if (stb.hostDataWe) dataReg <= regWdata;
  end

  always_comb begin
    if (regAddr == CMD_OFF)
      regRdata = {busy, lastOp, running, writeEnable, 2'b00, addrField};
    else if (regAddr == DATA_OFF)
      regRdata = dataReg;
    else
      regRdata = '0;
  end

endmodule

// File: rtl/eeprom_cmd_unit.sv
module eeprom_cmd_unit
  import eeprom_cmd_pkg::*;
#(
  parameter int                REG_AW      = 5,
  parameter logic [REG_AW-1:0] CMD_OFF     = 5'h14,
  parameter int                WORD_AW     = 8,
  parameter int                ACCESS_LAT  = 4,
  parameter int                LOAD_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [15:0]       regWdata,
  output logic [15:0]       regRdata,
  input  logic              writeEnable
);

  logic               busy;
  logic               running;
  logic [2:0]         lastOp;
  logic [WORD_AW-1:0] lastAddr;
  logic [15:0]        dataReg;
  dpStrobe_t          stb;
  logic               memWe;
  logic               dataLoad;

  assign memWe    = stb.memWe;
  assign dataLoad = stb.dataLoad;

  eeprom_cmd_ctrl #(
    .REG_AW(REG_AW), .CMD_OFF(CMD_OFF), .WORD_AW(WORD_AW),
    .ACCESS_LAT(ACCESS_LAT), .LOAD_CYCLES(LOAD_CYCLES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .writeEnable(writeEnable), .busy(busy),
    .running(running), .lastOp(lastOp), .lastAddr(lastAddr), .stb(stb)
  );

  eeprom_cmd_dpath #(
    .REG_AW(REG_AW), .CMD_OFF(CMD_OFF), .WORD_AW(WORD_AW)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .wordAddr(lastAddr),
    .regAddr(regAddr), .regWdata(regWdata), .busy(busy),
    .running(running), .lastOp(lastOp), .writeEnable(writeEnable),
    .dataReg(dataReg), .regRdata(regRdata)
  );

endmodule

// File: rtl/eeprom_cmd_chk.sv
module eeprom_cmd_chk #(
  parameter int                REG_AW  = 5,
  parameter logic [REG_AW-1:0] CMD_OFF = 5'h14,
  parameter int                WORD_AW = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               regWe,
  input logic [REG_AW-1:0]  regAddr,
  input logic               cmdGo,
  input logic               writeEnable,
  input logic               busy,
  input logic               running,
  input logic [2:0]         lastOp,
  input logic [WORD_AW-1:0] lastAddr,
  input logic               memWe,
  input logic               dataLoad,
  input logic [15:0]        dataReg
);

  logic cmdWr;
  assign cmdWr = regWe && (regAddr == CMD_OFF);

  a_r1_no_store_in_load: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> !running);

  a_r2_ignore_when_active: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && (busy || running)) |=> ($stable(lastOp) && $stable(lastAddr)));

  a_r3_strobe_inside_busy: assert property (@(posedge clk) disable iff (!rstN)
    (memWe || dataLoad) |-> busy);

  a_r4_store_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> writeEnable);

  a_r5_strobes_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(memWe && dataLoad));

  a_r9_no_start_without_flag: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && !cmdGo) |=> ($stable(lastOp) && $stable(lastAddr)));

  a_r10_data_held_when_active: assert property (@(posedge clk) disable iff (!rstN)
    ((busy || running) && !dataLoad) |=> $stable(dataReg));

endmodule

bind eeprom_cmd_unit eeprom_cmd_chk #(
  .REG_AW(REG_AW), .CMD_OFF(CMD_OFF), .WORD_AW(WORD_AW)
) u_chk (
  .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
  .cmdGo(regWdata[15]), .writeEnable(writeEnable), .busy(busy),
  .running(running), .lastOp(lastOp), .lastAddr(lastAddr),
  .memWe(memWe), .dataLoad(dataLoad), .dataReg(dataReg)
);

// File: tb/sim_eeprom_cmd_unit.sv
`timescale 1ns/1ps
module sim_eeprom_cmd_unit;

  localparam int              REG_AW  = 5;
  localparam logic [4:0]      CMD     = 5'h14;
  localparam logic [4:0]      DATA    = 5'h15;
  localparam int              LAT     = 4;
  localparam int              LOADN   = 16;

  typedef struct {
    logic [15:0] exp;
    string       req;
  } sbItem_t;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              regWe = 1'b0;
  logic [REG_AW-1:0] regAddr = CMD;
  logic [15:0]       regWdata = '0;
  logic [15:0]       regRdata;
  logic              writeEnable = 1'b1;

  int      nChecks = 0;
  int      nErrors = 0;
  sbItem_t expQ[$];
  event    sampleEv;

  always #2.5 clk = ~clk;

  eeprom_cmd_unit #(
    .REG_AW(REG_AW), .CMD_OFF(CMD), .WORD_AW(8),
    .ACCESS_LAT(LAT), .LOAD_CYCLES(LOADN)
  ) u0 (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .writeEnable(writeEnable)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic peek(input logic [4:0] a, output logic [15:0] v);
    regAddr = a;
    #1;
    v = regRdata;
  endtask

  task automatic regWrite(input logic [4:0] a, input logic [15:0] v);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = v;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  // count consecutive negedges on which the masked status bits are set
  task automatic measure(input logic [15:0] mask, output int n);
    logic [15:0] v;
    n = 0;
    for (int i = 0; i < 1000; i++) begin
      peek(CMD, v);
      if ((v & mask) == 0) break;
      n++;
      @(negedge clk);
    end
  endtask

  task automatic waitIdle();
    int n;
    measure(16'h8800, n);
  endtask

  // driver: push the expected word, issue the read, hand over to the monitor
  task automatic readWord(input logic [7:0] a, input logic [15:0] exp, input string req);
    int n;
    sbItem_t it;
    it.exp = exp; it.req = req;
    expQ.push_back(it);
    regWrite(CMD, 16'hC000 | 16'(a));
    measure(16'h8000, n);
    check("R5 read busy cycles", 16'(n), 16'(LAT));
    regAddr = DATA;
    #1;
    ->sampleEv;
    #1;
  endtask

  // monitor: compare the data register against the scoreboard head
  initial begin
    forever begin
      sbItem_t it;
      @(sampleEv);
      if (expQ.size() == 0) begin
        check("scoreboard underflow", 16'h0, 16'h1);
      end else begin
        it = expQ.pop_front();
        check(it.req, regRdata, it.exp);
      end
    end
  end

  initial begin
    #(5.0 * 150000);
    nChecks++; nErrors++;
    $display("FAIL watchdog expired actual %h expected %h", 16'h0, 16'h1);
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int n;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 / R8: power-on load
    peek(CMD, v);
    check("R8 reset command readback", v, 16'h0C00);
    measure(16'h0800, n);
    check("R1 power-on running cycles", 16'(n), 16'(LOADN));
    peek(CMD, v);
    check("R1 status after load", v, 16'h0400);

    // R3: store two words
    regWrite(DATA, 16'hA5A5);
    regWrite(CMD, 16'hB010);
    measure(16'h8000, n);
    check("R3 write busy cycles", 16'(n), 16'(LAT));
    peek(CMD, v);
    check("R8 command after write", v, 16'h3410);
    regWrite(DATA, 16'h5A5A);
    regWrite(CMD, 16'hB0FF);
    waitIdle();
    readWord(8'h10, 16'hA5A5, "R3 word 0x10");
    readWord(8'hFF, 16'h5A5A, "R5 word 0xFF");

    // R2 / R10: commands and data writes during an access
    regWrite(DATA, 16'h1111);
    regWrite(CMD, 16'hB020);
    regWrite(CMD, 16'hC010);
    regWrite(DATA, 16'h3333);
    waitIdle();
    peek(CMD, v);
    check("R2 ignored command", v, 16'h3420);
    peek(DATA, v);
    check("R10 data write during access", v, 16'h1111);
    readWord(8'h20, 16'h1111, "R3 word 0x20");

    // R4: store while locked
    writeEnable = 1'b0;
    regWrite(DATA, 16'h2222);
    regWrite(CMD, 16'hB010);
    measure(16'h8000, n);
    check("R4 locked write busy cycles", 16'(n), 16'(LAT));
    peek(CMD, v);
    check("R8 write-enable bit low", v, 16'h3010);
    writeEnable = 1'b1;
    readWord(8'h10, 16'hA5A5, "R4 word unchanged");

    // R7: unknown opcodes
    regWrite(DATA, 16'h7777);
    regWrite(CMD, 16'hF010);
    measure(16'h8000, n);
    check("R7 opcode 7 busy cycles", 16'(n), 16'd1);
    peek(DATA, v);
    check("R7 data unchanged", v, 16'h7777);
    regWrite(CMD, 16'h8033);
    measure(16'h8000, n);
    check("R7 opcode 0 busy cycles", 16'(n), 16'd1);
    peek(CMD, v);
    check("R8 command after no-op", v, 16'h0433);
    readWord(8'h10, 16'hA5A5, "R7 word unchanged");

    // R6: host load
    regWrite(DATA, 16'h4444);
    regWrite(CMD, 16'hE0FF);
    peek(CMD, v);
    check("R6 load status bits", v, 16'hECFF);
    measure(16'h8000, n);
    check("R6 load busy cycles", 16'(n), 16'(LOADN));
    regWrite(CMD, 16'hE0FF);
    regWrite(DATA, 16'h9999);
    waitIdle();
    peek(DATA, v);
    check("R10 data write during load", v, 16'h4444);
    readWord(8'hFF, 16'h5A5A, "R6 word unchanged");

    // R9: command without start flag
    regWrite(CMD, 16'h4010);
    peek(CMD, v);
    check("R9 no start", v, 16'h44FF);
    @(negedge clk);
    peek(CMD, v);
    check("R9 still idle", v, 16'h44FF);

    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

endmodule